// File: doc/BRIEF.md
# Port-Based Address Table Flush Sequencer

This block removes learned addresses that belong to a set of switch ports. When started, it walks every entry of an external address table in index order. For each entry it reads the word, decides whether the entry refers to any of the ports being flushed, and writes the edited word back. Single-destination (unicast) entries are released when their port is in the flush set. Group (multicast) entries lose the flushed ports from their destination mask, and are released once no destination is left.

A group-only mode narrows the sweep to group entries. In this mode it can be limited to one VLAN, and it never edits the all-ones broadcast address. The table is reached through a one-cycle-latency read port and a write port. The sequencer reports `busy` while sweeping and pulses `done` at the end.

The controller has five states. `ST_IDLE` waits for `start` (transition *accept*). `ST_READ` issues the read for the current index (transition *fetch*). `ST_EVAL` captures the returned word and its edited form (transition *decide*). `ST_WBACK` writes the word back if it changed, then moves either to `ST_READ` for the next index (transition *advance*) or to `ST_DONE` after the last one (transition *finish*). `ST_DONE` lasts one cycle and returns to `ST_IDLE` (transition *release*).

Top module: `tbl_flush_seq`

## Requirements
- R1: A sweep reads indices 0 to NUM_ENTRIES-1 in ascending order, one read per index, spending three cycles per index. `done` is high for exactly one cycle, 3*NUM_ENTRIES+1 cycles after the clock edge that samples `start`.
- R2: Only entries whose kind field (bits 61:60) is 1 (address) or 3 (VLAN plus address) are edited. Entries of kind 0 (free) or 2 (VLAN only) are never written.
- R3: An entry with bit 40 clear is unicast, and its port number is in bits 67:66. Outside group-only mode, it is released (bits 61:60 set to 0, all other bits kept) when `flush_mask` has the bit for that port set. Port number 3 is never released.
- R4: An entry with bit 40 set is multicast, and its destination mask is in bits 68:66. If that mask shares no bit with `flush_mask`, the entry is unchanged. Otherwise the shared bits are cleared in bits 68:66.
- R5: A multicast entry whose destination mask would become zero is released instead: bits 61:60 become 0 and bits 68:66 keep their old value.
- R6: When `mc_only` is 1, unicast entries are untouched. Multicast entries are edited only if their VLAN field (bits 59:48) equals `vlan_sel`, or if `vlan_sel` is 12'hFFF. When `mc_only` is 0, the VLAN field is not consulted.
- R7: When `mc_only` is 1, a multicast entry whose address field (bits 47:0) is all ones is never written. When `mc_only` is 0, such an entry is flushed like any other multicast entry.
- R8: A write happens only when the edited word differs from the word read. It goes to the same index, and it is issued in the cycle after the read data returns.
- R9: `busy` is high from the cycle after `start` is accepted through the last write-back cycle. A `start` that arrives while `busy` is high is ignored. `flush_mask`, `mc_only` and `vlan_sel` are sampled only when `start` is accepted.
- R10: After reset, `busy`, `done`, `tbl_rd_en` and `tbl_wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a sweep (accepted only when idle) |
| mc_only | input | 1 | 1: edit multicast entries only |
| flush_mask | input | 3 | Ports to remove |
| vlan_sel | input | 12 | VLAN filter in group-only mode; all ones matches every VLAN |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| tbl_rd_en | output | 1 | Table read request |
| tbl_rd_idx | output | IDX_W | Table read index |
| tbl_rd_data | input | 72 | Table word, valid the cycle after the request |
| tbl_wr_en | output | 1 | Table write request |
| tbl_wr_idx | output | IDX_W | Table write index |
| tbl_wr_data | output | 72 | Table word to write |

## Verification
The table is loaded with a mix of entries: unicast entries on each port number including port 3, multicast entries with single and multiple destinations, broadcast entries, and free and VLAN-only entries whose other bits look like flushable entries. Five sweeps run over this table.

- A full flush of one port shows the difference between a multicast mask being reduced and a multicast entry being released.
- A group-only sweep filtered to one VLAN shows that unicast, other-VLAN and broadcast entries are protected.
- A group-only sweep with the all-VLAN value and a full mask releases every non-broadcast multicast entry.
- A two-port full flush, with a conflicting `start` injected mid-sweep, shows that the first configuration is kept. It also shows broadcast entries being flushed outside group-only mode.
- An empty mask must produce no writes at all.

// File: rtl/tbl_flush_pkg.sv
`timescale 1ns/1ps
package tbl_flush_pkg;
    localparam int ENTRY_W   = 72;
    localparam int KIND_LO   = 60;
    localparam int VID_LO    = 48;
    localparam int VID_W     = 12;
    localparam int GROUP_BIT = 40;
    localparam int MAC_W     = 48;
    localparam int PORT_LO   = 66;
    localparam int PMASK_W   = 3;
    localparam int PNUM_W    = 2;

    typedef enum logic [1:0] {
        KIND_FREE      = 2'd0,
        KIND_ADDR      = 2'd1,
        KIND_VLAN      = 2'd2,
        KIND_VLAN_ADDR = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_WBACK,
        ST_DONE
    } seq_state_e;
endpackage

// File: rtl/flush_entry_edit.sv
`timescale 1ns/1ps
module flush_entry_edit
    import tbl_flush_pkg::*;
(
    input  logic [ENTRY_W-1:0] word_in,
    input  logic [PMASK_W-1:0] drop_mask,
    input  logic               grp_only,
    input  logic [VID_W-1:0]   vid_sel,
    output logic [ENTRY_W-1:0] word_out,
    output logic               differs
);
    localparam int NUM_CODES = 1 << PNUM_W;

    logic [1:0]           kind;
    logic                 is_addr;
    logic                 is_group;
    logic                 vid_hit;
    logic                 is_bcast;
    logic [PMASK_W-1:0]   dest;
    logic [PMASK_W-1:0]   remain;
    logic [PNUM_W-1:0]    pnum;
    logic [NUM_CODES-1:0] drop_ext;

    always_comb begin
        kind     = word_in[KIND_LO +: 2];
        is_addr  = (kind == KIND_ADDR) || (kind == KIND_VLAN_ADDR);
        is_group = word_in[GROUP_BIT];
        vid_hit  = (vid_sel == '1) || (word_in[VID_LO +: VID_W] == vid_sel);
        is_bcast = (word_in[MAC_W-1:0] == '1);
        dest     = word_in[PORT_LO +: PMASK_W];
        remain   = dest & ~drop_mask;
        pnum     = word_in[PORT_LO +: PNUM_W];
        drop_ext = NUM_CODES'(drop_mask);
        word_out = word_in;
        if (is_addr) begin
            if (is_group) begin
                if (!grp_only || (vid_hit && !is_bcast)) begin
                    if ((dest & drop_mask) != '0) begin
                        if (remain != '0)
                            word_out[PORT_LO +: PMASK_W] = remain;
                        else
                            word_out[KIND_LO +: 2] = KIND_FREE;
                    end
                end
            end else if (!grp_only) begin
                if (drop_ext[pnum])
                    word_out[KIND_LO +: 2] = KIND_FREE;
            end
        end
        differs = (word_out != word_in);
    end
endmodule

// File: rtl/flush_idx_ctr.sv
`timescale 1ns/1ps
module flush_idx_ctr #(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [IDX_W-1:0] idx,
    output logic             at_last
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    always_ff @(posedge clk) begin
        if (!rst_n)
            idx <= '0;
        else if (clr)
            idx <= '0;
        else if (inc)
            idx <= idx + 1'b1;
    end

    assign at_last = (idx == LAST_IDX);
endmodule

// File: rtl/flush_seq_ctrl.sv
`timescale 1ns/1ps
module flush_seq_ctrl
    import tbl_flush_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic at_last,
    output logic accept,
    output logic rd_req,
    output logic eval_cyc,
    output logic wb_cyc,
    output logic step,
    output logic busy,
    output logic done
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_READ;
            ST_READ:  state_d = ST_EVAL;
            ST_EVAL:  state_d = ST_WBACK;
            ST_WBACK: state_d = at_last ? ST_DONE : ST_READ;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        accept   = 1'b0;
        rd_req   = 1'b0;
        eval_cyc = 1'b0;
        wb_cyc   = 1'b0;
        step     = 1'b0;
        busy     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:  accept = start;
            ST_READ:  begin rd_req = 1'b1;   busy = 1'b1; end
            ST_EVAL:  begin eval_cyc = 1'b1; busy = 1'b1; end
            ST_WBACK: begin wb_cyc = 1'b1;   busy = 1'b1; step = !at_last; end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/tbl_flush_seq.sv
`timescale 1ns/1ps
module tbl_flush_seq
    import tbl_flush_pkg::*;
#(
    parameter int NUM_ENTRIES = 16,
    parameter int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               mc_only,
    input  logic [PMASK_W-1:0] flush_mask,
    input  logic [VID_W-1:0]   vlan_sel,
    output logic               busy,
    output logic               done,
    output logic               tbl_rd_en,
    output logic [IDX_W-1:0]   tbl_rd_idx,
    input  logic [ENTRY_W-1:0] tbl_rd_data,
    output logic               tbl_wr_en,
    output logic [IDX_W-1:0]   tbl_wr_idx,
    output logic [ENTRY_W-1:0] tbl_wr_data
);
    logic               accept, eval_cyc, wb_cyc, step, at_last;
    logic [IDX_W-1:0]   idx;
    logic [PMASK_W-1:0] mask_q;
    logic               grp_q;
    logic [VID_W-1:0]   vid_q;
    logic [ENTRY_W-1:0] edited;
    logic               differs;
    logic [ENTRY_W-1:0] wb_data_q;
    logic               wb_chg_q;

    flush_seq_ctrl ctrl_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .at_last  (at_last),
        .accept   (accept),
        .rd_req   (tbl_rd_en),
        .eval_cyc (eval_cyc),
        .wb_cyc   (wb_cyc),
        .step     (step),
        .busy     (busy),
        .done     (done)
    );

    flush_idx_ctr #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) ctr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (accept),
        .inc     (step),
        .idx     (idx),
        .at_last (at_last)
    );

    flush_entry_edit edit_i (
        .word_in   (tbl_rd_data),
        .drop_mask (mask_q),
        .grp_only  (grp_q),
        .vid_sel   (vid_q),
        .word_out  (edited),
        .differs   (differs)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            grp_q  <= 1'b0;
            vid_q  <= '0;
        end else if (accept) begin
            mask_q <= flush_mask;
            grp_q  <= mc_only;
            vid_q  <= vlan_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_data_q <= '0;
            wb_chg_q  <= 1'b0;
        end else if (eval_cyc) begin
            wb_data_q <= edited;
            wb_chg_q  <= differs;
        end
    end

    assign tbl_rd_idx  = idx;
    assign tbl_wr_idx  = idx;
    assign tbl_wr_en   = wb_cyc && wb_chg_q;
    assign tbl_wr_data = wb_data_q;
endmodule

// File: rtl/tbl_flush_seq_chk.sv
`timescale 1ns/1ps
module tbl_flush_seq_chk #(
    parameter int IDX_W   = 4,
    parameter int ENTRY_W = 72
) (
    input logic               clk,
    input logic               rst_n,
    input logic               busy,
    input logic               done,
    input logic               tbl_rd_en,
    input logic [IDX_W-1:0]   tbl_rd_idx,
    input logic [ENTRY_W-1:0] tbl_rd_data,
    input logic               tbl_wr_en,
    input logic [IDX_W-1:0]   tbl_wr_idx,
    input logic [ENTRY_W-1:0] tbl_wr_data
);
    // R8
    wr_only_changed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> tbl_wr_data != $past(tbl_rd_data));

    // R8
    wr_same_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> tbl_wr_idx == $past(tbl_rd_idx, 2));

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R1
    done_after_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R9
    rd_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_rd_en |-> busy);

    // R9
    wr_in_sweep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_wr_en |-> busy);
endmodule

bind tbl_flush_seq tbl_flush_seq_chk #(.IDX_W(IDX_W), .ENTRY_W(tbl_flush_pkg::ENTRY_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .tbl_rd_en   (tbl_rd_en),
    .tbl_rd_idx  (tbl_rd_idx),
    .tbl_rd_data (tbl_rd_data),
    .tbl_wr_en   (tbl_wr_en),
    .tbl_wr_idx  (tbl_wr_idx),
    .tbl_wr_data (tbl_wr_data)
);

// File: tb/tbl_flush_seq_tb_top.sv
`timescale 1ns/1ps
module tbl_flush_seq_tb_top;
    localparam int N  = 16;
    localparam int IW = $clog2(N);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mc_only = 1'b0;
    logic [2:0]  flush_mask = '0;
    logic [11:0] vlan_sel = '0;
    logic        busy, done, tbl_rd_en, tbl_wr_en;
    logic [IW-1:0] tbl_rd_idx, tbl_wr_idx;
    logic [71:0] tbl_rd_data, tbl_wr_data;

    logic [71:0] mem [N];
    logic [71:0] exp_mem [N];

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [71:0]   data;
    } wr_item_t;
    wr_item_t exp_q[$];

    int checks = 0;
    int errors = 0;
    int exp_rd = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tbl_flush_seq #(.NUM_ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mc_only(mc_only),
        .flush_mask(flush_mask), .vlan_sel(vlan_sel), .busy(busy), .done(done),
        .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx), .tbl_rd_data(tbl_rd_data),
        .tbl_wr_en(tbl_wr_en), .tbl_wr_idx(tbl_wr_idx), .tbl_wr_data(tbl_wr_data)
    );

    // table model: one-cycle read latency
    always @(posedge clk) begin
        if (tbl_rd_en) tbl_rd_data <= mem[tbl_rd_idx];
        if (tbl_wr_en) mem[tbl_wr_idx] <= tbl_wr_data;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // monitor: scoreboard pop on every write, read order check
    always @(negedge clk) begin
        if (rst_n && tbl_rd_en) begin
            chk(int'(tbl_rd_idx) == exp_rd, "R1", "read index order",
                72'(tbl_rd_idx), 72'(exp_rd));
            exp_rd++;
        end
        if (rst_n && tbl_wr_en) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R8", "unexpected write", {tbl_wr_idx, tbl_wr_data[67:0]}, 72'd0);
            end else begin
                wr_item_t it;
                it = exp_q.pop_front();
                chk(tbl_wr_idx == it.idx, "R8", "write index",
                    72'(tbl_wr_idx), 72'(it.idx));
                chk(tbl_wr_data == it.data, "R3/R4/R5", "write data",
                    tbl_wr_data, it.data);
            end
        end
    end

    function automatic logic [71:0] mk(input logic [1:0] kind, input logic [11:0] vid,
                                       input logic [47:0] mac, input logic [2:0] pf);
        logic [71:0] e;
        e = '0;
        e[71:69] = 3'b101;
        e[68:66] = pf;
        e[61:60] = kind;
        e[59:48] = vid;
        e[47:0]  = mac;
        return e;
    endfunction

    function automatic logic [71:0] ref_edit(input logic [71:0] e, input logic [2:0] m,
                                             input bit mc, input logic [11:0] v);
        logic [71:0] r;
        logic [2:0]  pm;
        int          pn;
        r  = e;
        pm = e[68:66];
        pn = int'(e[67:66]);
        if (e[61:60] == 2'd1 || e[61:60] == 2'd3) begin
            if (e[40]) begin
                if (mc && ((v != 12'hFFF && e[59:48] != v) || e[47:0] == 48'hFFFF_FFFF_FFFF)) begin
                    r = e;
                end else if ((pm & m) != 3'b000) begin
                    if ((pm & ~m) != 3'b000) r[68:66] = pm & ~m;
                    else r[61:60] = 2'd0;
                end
            end else if (!mc) begin
                if (pn < 3 && m[pn]) r[61:60] = 2'd0;
            end
        end
        return r;
    endfunction

    task automatic load_table();
        logic [71:0] t [N];
        t[0]  = mk(2'd1, 12'd0, 48'h0000_1111_2222, 3'b000); // uc port0
        t[1]  = mk(2'd3, 12'd5, 48'h0200_0000_0001, 3'b001); // uc port1
        t[2]  = mk(2'd1, 12'd0, 48'h0200_0000_0002, 3'b010); // uc port2
        t[3]  = mk(2'd1, 12'd0, 48'h0200_0000_0003, 3'b011); // uc port3
        t[4]  = mk(2'd1, 12'd0, 48'h0100_5E00_0001, 3'b011); // mc
        t[5]  = mk(2'd3, 12'd5, 48'h0100_5E00_0002, 3'b100); // mc vlan5
        t[6]  = mk(2'd3, 12'd7, 48'h0100_5E00_0003, 3'b110); // mc vlan7
        t[7]  = mk(2'd1, 12'd0, 48'hFFFF_FFFF_FFFF, 3'b111); // bcast
        t[8]  = mk(2'd3, 12'd5, 48'hFFFF_FFFF_FFFF, 3'b010); // bcast vlan5
        t[9]  = mk(2'd2, 12'd5, 48'h0100_5E00_0009, 3'b111); // vlan-only kind
        t[10] = mk(2'd0, 12'd5, 48'h0100_5E00_000A, 3'b111); // free kind
        t[11] = mk(2'd1, 12'd0, 48'h0100_5E00_000B, 3'b001); // mc single
        t[12] = mk(2'd3, 12'd7, 48'h0200_0000_000C, 3'b000); // uc port0 vlan7
        for (int i = 13; i < N; i++) t[i] = '0;
        for (int i = 0; i < N; i++) begin
            mem[i] = t[i];
            exp_mem[i] = t[i];
        end
    endtask

    task automatic run_sweep(input logic [2:0] m, input bit mc, input logic [11:0] v,
                             input bit inject, input string tag);
        int cyc;
        for (int i = 0; i < N; i++) begin
            logic [71:0] nw;
            nw = ref_edit(exp_mem[i], m, mc, v);
            if (nw != exp_mem[i]) begin
                exp_q.push_back('{idx: IW'(i), data: nw});
                exp_mem[i] = nw;
            end
        end
        exp_rd = 0;
        @(posedge clk); #1;
        start = 1'b1; flush_mask = m; mc_only = mc; vlan_sel = v;
        cyc = 0;
        @(posedge clk); #1;
        start = 1'b0; flush_mask = ~m; mc_only = ~mc; vlan_sel = ~v; // R9 sampled once
        cyc = 1;
        chk(busy == 1'b1, "R9", {tag, " busy after accept"}, 72'(busy), 72'd1);
        while (!done && cyc < 4 * N + 10) begin
            if (inject && cyc == 5) start = 1'b1; // R9 ignored mid-sweep
            else start = 1'b0;
            @(posedge clk); #1;
            cyc++;
        end
        start = 1'b0;
        chk(cyc == 3 * N + 1, "R1", {tag, " done cycle"}, 72'(cyc), 72'(3 * N + 1));
        @(posedge clk); #1;
        chk(done == 1'b0 && busy == 1'b0, "R1", {tag, " done one cycle"},
            72'({done, busy}), 72'd0);
        repeat (4) @(posedge clk);
        #1;
        chk(busy == 1'b0, "R9", {tag, " no second sweep"}, 72'(busy), 72'd0);
        chk(exp_q.size() == 0, "R8", {tag, " pending writes"}, 72'(exp_q.size()), 72'd0);
        exp_q.delete();
        for (int i = 0; i < N; i++)
            chk(mem[i] == exp_mem[i], "R2/R6/R7", {tag, " table entry"}, mem[i], exp_mem[i]);
    endtask

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        load_table();
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        chk({busy, done, tbl_rd_en, tbl_wr_en} == 4'b0, "R10", "reset outputs",
            72'({busy, done, tbl_rd_en, tbl_wr_en}), 72'd0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk({busy, done, tbl_rd_en, tbl_wr_en} == 4'b0, "R10", "idle after reset",
            72'({busy, done, tbl_rd_en, tbl_wr_en}), 72'd0);

        // R3 R4 R5: full flush of port 0
        run_sweep(3'b001, 1'b0, 12'd0, 1'b0, "full_p0");
        // R6 R7: multicast-only, vlan 5
        load_table();
        run_sweep(3'b110, 1'b1, 12'd5, 1'b0, "mc_vlan5");
        // R6 R7: multicast-only, every vlan, all ports
        load_table();
        run_sweep(3'b111, 1'b1, 12'hFFF, 1'b0, "mc_all");
        // R9 R7: full flush with ignored second start, broadcast flushed
        load_table();
        run_sweep(3'b110, 1'b0, 12'd0, 1'b1, "full_p12_inject");
        // R8: empty mask writes nothing
        load_table();
        run_sweep(3'b000, 1'b0, 12'd0, 1'b0, "empty_mask");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule